// File: doc/BRIEF.md
# Sleep Wake-Up Source Selector

This block sits in the power controller of a small microcontroller. While the core sleeps with its clock stopped, it watches a group of input pins and issues a single wake pulse when the chosen pin event occurs. A small control register picks the event source. The source can be one of four pins of port B, the top pin of port A, or a NOR of the lower half or of all of port A. The register also holds a global level polarity and a choice between a long reset delay and a fast restart after wake.

When the register selects a fast restart, the source must hold its active level for a minimum number of clock cycles before the wake is accepted. A warm-start status bit is set on sleep entry. It stays set through a pin-driven wake and is cleared only by reset, so software can tell a pin wake from a cold start. For a port-A pin that is configured as an output, the block samples the level the chip drives on it, not the pad.

Top module: `wake_src_sel`

## Requirements
- R1: After reset the register reads 8'h10: source code 0, polarity 0, delay enable 1, warm status 0. All request outputs are low.
- R2: The register layout is source code in bits [2:0], polarity in bit 3, delay enable in bit 4, and warm status in bit 7. Bits 6:5 read 0. Writes to bit 7 are ignored.
- R3: Source codes 1 to 4 select port B bits 0 to 3. Code 5 selects port A bit 7.
- R4: Code 6 uses the NOR of port A bits [PA_W/2-1:0] as the source. Code 7 uses the NOR of all port A bits.
- R5: With code 0 no pin activity ever produces a wake.
- R6: While analog_en is 1, codes 2, 3 and 4 never produce a wake. Code 1 is unaffected.
- R7: With polarity 1 a high source level is active. With polarity 0 a low level is active.
- R8: Pins pass through a two-stage synchronizer. With delay enable 1 and sleep already active, wake_pulse rises exactly three clock edges after a pin becomes active.
- R9: With delay enable 1, a wake asserts long_delay_req together with wake_pulse. With delay enable 0, the wake asserts fast_restart_req instead, and only after the source has been active for QUAL_CYC consecutive sleeping cycles.
- R10: wake_pulse lasts one cycle. It is issued only while sleep_active is 1, and at most once between two sleep_enter pulses.
- R11: warm_start (register bit 7) is set by sleep_enter and is cleared only by reset.
- R12: For a port A bit whose pa_oe bit is 1, the wake logic uses the pa_dout bit instead of the pad.
- R13: The fast-restart qualification count restarts from zero whenever the source goes inactive and whenever sleep_enter occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| pa_pad | input | PA_W | Port A pad levels |
| pa_oe | input | PA_W | Port A output-enable per bit |
| pa_dout | input | PA_W | Port A driven output levels |
| pb_pad | input | PB_W | Port B pad levels |
| analog_en | input | 1 | Port B bits 1 to 3 in analog use |
| sleep_enter | input | 1 | One-cycle pulse on sleep entry |
| sleep_active | input | 1 | High while the core sleeps |
| wake_pulse | output | 1 | One-cycle wake event |
| long_delay_req | output | 1 | Wake requests the full reset delay |
| fast_restart_req | output | 1 | Wake requests a fast restart |
| warm_start | output | 1 | Warm-start status |

## Verification
The bench builds the block with its defaults: PA_W of 8, PB_W of 4, QUAL_CYC of 5 and SYNC_STAGES of 2. The short qualification window lets the bench reach counter saturation, a gap that resets the count, and an exact three-edge wake latency within a few cycles. The 8-bit port A lets it drive all eight source codes, including both NOR groups and the output-enable override, against a per-clock model.

// File: rtl/wss_pkg.sv
`timescale 1ns/1ps
package wss_pkg;

    // Source code values; the numbering is decoded by the selector.
    typedef enum logic [2:0] {
        SRC_NONE    = 3'd0,
        SRC_B0      = 3'd1,
        SRC_B1      = 3'd2,
        SRC_B2      = 3'd3,
        SRC_B3      = 3'd4,
        SRC_A7      = 3'd5,
        SRC_NOR_LO  = 3'd6,
        SRC_NOR_ALL = 3'd7
    } src_sel_e;

    localparam int POL_BIT  = 3;
    localparam int DLY_BIT  = 4;
    localparam int WARM_BIT = 7;

    typedef struct packed {
        logic     warm;
        logic     dly_en;
        logic     pol;
        src_sel_e sel;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic woke;
        logic wake;
        logic lng;
        logic fst;
    } ctrl_st_t;

    localparam cfg_t CFG_RST = '{warm: 1'b0, dly_en: 1'b1, pol: 1'b0, sel: SRC_NONE};

endpackage

// File: rtl/wss_sync.sv
`timescale 1ns/1ps
module wss_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q[STAGES-1];

endmodule

// File: rtl/wss_src_mux.sv
`timescale 1ns/1ps
module wss_src_mux
    import wss_pkg::*;
#(
    parameter int PA_W = 8,
    parameter int PB_W = 4
) (
    input  logic [PA_W-1:0] pa_s,
    input  logic [PB_W-1:0] pb_s,
    input  src_sel_e        sel,
    input  logic            pol,
    input  logic            analog_en,
    output logic            src_active
);

    localparam int LO_W = PA_W / 2;

    logic raw;
    logic valid;
    logic nor_lo;
    logic nor_all;

    always_comb begin
        nor_lo  = ~|pa_s[LO_W-1:0];
        nor_all = ~|pa_s;
    end

    always_comb begin
        raw   = 1'b0;
        valid = 1'b1;
        unique case (sel)
            SRC_NONE:    valid = 1'b0;
            SRC_B0:      raw = pb_s[0];
            SRC_B1: begin
                raw   = pb_s[1];
                valid = !analog_en;
            end
            SRC_B2: begin
                raw   = pb_s[2];
                valid = !analog_en;
            end
            SRC_B3: begin
                raw   = pb_s[3];
                valid = !analog_en;
            end
            SRC_A7:      raw = pa_s[PA_W-1];
            SRC_NOR_LO:  raw = nor_lo;
            SRC_NOR_ALL: raw = nor_all;
            default:     valid = 1'b0;
        endcase
    end

    assign src_active = valid && (pol ? raw : !raw);

endmodule

// File: rtl/wss_qual.sv
`timescale 1ns/1ps
module wss_qual #(
    parameter int QUAL_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sleep_active,
    input  logic sleep_enter,
    output logic qual_ok
);

    localparam int CW = $clog2(QUAL_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (sleep_enter || !active) begin
            cnt_d = '0;
        end else if (sleep_active && (cnt_q < LIMIT)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign qual_ok = (cnt_q == LIMIT);

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    assert_cnt_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_enter || !active) |=> (cnt_q == '0));

endmodule

// File: rtl/wake_src_sel.sv
`timescale 1ns/1ps
module wake_src_sel
    import wss_pkg::*;
#(
    parameter int PA_W        = 8,
    parameter int PB_W        = 4,
    parameter int QUAL_CYC    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [7:0]      cfg_wdata,
    output logic [7:0]      cfg_rdata,
    input  logic [PA_W-1:0] pa_pad,
    input  logic [PA_W-1:0] pa_oe,
    input  logic [PA_W-1:0] pa_dout,
    input  logic [PB_W-1:0] pb_pad,
    input  logic            analog_en,
    input  logic            sleep_enter,
    input  logic            sleep_active,
    output logic            wake_pulse,
    output logic            long_delay_req,
    output logic            fast_restart_req,
    output logic            warm_start
);

    localparam int SW = PA_W + PB_W;

    logic [PA_W-1:0] pa_eff;
    logic [SW-1:0]   sync_out;
    logic            src_active;
    logic            qual_ok;
    logic            wake_d;
    logic            unused_wbits;
    ctrl_st_t        s_d, s_q;

    // Driven output level takes the place of the pad for output bits.
    assign pa_eff = (pa_oe & pa_dout) | (~pa_oe & pa_pad);

    wss_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({pb_pad, pa_eff}),
        .dout  (sync_out)
    );

    wss_src_mux #(.PA_W(PA_W), .PB_W(PB_W)) u_mux (
        .pa_s       (sync_out[PA_W-1:0]),
        .pb_s       (sync_out[SW-1:PA_W]),
        .sel        (s_q.cfg.sel),
        .pol        (s_q.cfg.pol),
        .analog_en  (analog_en),
        .src_active (src_active)
    );

    wss_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (src_active),
        .sleep_active (sleep_active),
        .sleep_enter  (sleep_enter),
        .qual_ok      (qual_ok)
    );

    assign unused_wbits = ^cfg_wdata[7:5];

    always_comb begin
        s_d    = s_q;
        wake_d = sleep_active && !sleep_enter && !s_q.woke && src_active
                 && (s_q.cfg.dly_en || qual_ok);
        s_d.wake = wake_d;
        s_d.lng  = wake_d && s_q.cfg.dly_en;
        s_d.fst  = wake_d && !s_q.cfg.dly_en;
        if (sleep_enter) begin
            s_d.woke     = 1'b0;
            s_d.cfg.warm = 1'b1;
        end else if (wake_d) begin
            s_d.woke = 1'b1;
        end
        if (cfg_we) begin
            s_d.cfg.sel    = src_sel_e'(cfg_wdata[2:0]);
            s_d.cfg.pol    = cfg_wdata[POL_BIT];
            s_d.cfg.dly_en = cfg_wdata[DLY_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cfg: CFG_RST, woke: 1'b0, wake: 1'b0, lng: 1'b0, fst: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        cfg_rdata           = '0;
        cfg_rdata[2:0]      = s_q.cfg.sel;
        cfg_rdata[POL_BIT]  = s_q.cfg.pol;
        cfg_rdata[DLY_BIT]  = s_q.cfg.dly_en;
        cfg_rdata[WARM_BIT] = s_q.cfg.warm;
    end

    assign wake_pulse       = s_q.wake;
    assign long_delay_req   = s_q.lng;
    assign fast_restart_req = s_q.fst;
    assign warm_start       = s_q.cfg.warm;

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    assert_wake_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(sleep_active));

    assert_req_split_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (long_delay_req != fast_restart_req));

    assert_req_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_pulse |-> !(long_delay_req || fast_restart_req));

    assert_none_code0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cfg.sel == SRC_NONE) |-> !src_active);

    assert_analog_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (analog_en && (s_q.cfg.sel inside {SRC_B1, SRC_B2, SRC_B3})) |-> !src_active);

    assert_warm_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_enter |=> warm_start);

endmodule

// File: tb/sim_wake_src_sel.sv
`timescale 1ns/1ps
module sim_wake_src_sel;

    localparam int CLK_P = 10;
    localparam int QUAL  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [7:0] pa_pad = '0, pa_oe = '0, pa_dout = '0;
    logic [3:0] pb_pad = '0;
    logic       analog_en = 1'b0, sleep_enter = 1'b0, sleep_active = 1'b0;
    logic       wake_pulse, long_delay_req, fast_restart_req, warm_start;

    int    n_chk = 0, n_bad = 0, wake_seen = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    wake_src_sel u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pa_pad(pa_pad), .pa_oe(pa_oe), .pa_dout(pa_dout),
        .pb_pad(pb_pad), .analog_en(analog_en), .sleep_enter(sleep_enter),
        .sleep_active(sleep_active), .wake_pulse(wake_pulse),
        .long_delay_req(long_delay_req), .fast_restart_req(fast_restart_req),
        .warm_start(warm_start)
    );

    // Behavioural reference model
    logic [2:0] m_sel;
    logic       m_pol, m_dly, m_warm, m_woke, m_wake, m_lng, m_fst;
    int         m_cnt;
    logic [7:0] qa[$];
    logic [3:0] qb[$];

    always @(posedge clk) begin
        logic [7:0] a;
        logic [3:0] b;
        logic s, v, act, w;
        if (!rst_n) begin
            m_sel = 3'd0; m_pol = 0; m_dly = 1; m_warm = 0; m_woke = 0;
            m_wake = 0; m_lng = 0; m_fst = 0; m_cnt = 0;
            qa = '{8'h00, 8'h00};
            qb = '{4'h0, 4'h0};
        end else begin
            a = qa[0];
            b = qb[0];
            v = 1'b1; s = 1'b0;
            case (m_sel)
                3'd0: v = 1'b0;
                3'd1: s = b[0];
                3'd2: begin s = b[1]; v = !analog_en; end
                3'd3: begin s = b[2]; v = !analog_en; end
                3'd4: begin s = b[3]; v = !analog_en; end
                3'd5: s = a[7];
                3'd6: s = (a[3:0] == 4'h0);
                default: s = (a == 8'h00);
            endcase
            act = v && (m_pol ? s : !s);
            w = sleep_active && !sleep_enter && !m_woke && act && (m_dly || m_cnt >= QUAL);
            if (sleep_enter || !act) m_cnt = 0;
            else if (sleep_active && m_cnt < QUAL) m_cnt++;
            m_wake = w; m_lng = w && m_dly; m_fst = w && !m_dly;
            if (sleep_enter) begin m_woke = 0; m_warm = 1; end
            else if (w) m_woke = 1;
            if (cfg_we) begin
                m_sel = cfg_wdata[2:0]; m_pol = cfg_wdata[3]; m_dly = cfg_wdata[4];
            end
            void'(qa.pop_front()); qa.push_back((pa_oe & pa_dout) | (~pa_oe & pa_pad));
            void'(qb.pop_front()); qb.push_back(pb_pad);
        end
    end

    task automatic cmp(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("wake_pulse", {7'b0, wake_pulse}, {7'b0, m_wake});
            cmp("long_delay_req", {7'b0, long_delay_req}, {7'b0, m_lng});
            cmp("fast_restart_req", {7'b0, fast_restart_req}, {7'b0, m_fst});
            cmp("warm_start", {7'b0, warm_start}, {7'b0, m_warm});
            cmp("cfg_rdata", cfg_rdata, {m_warm, 2'b00, m_dly, m_pol, m_sel});
            if (wake_pulse) wake_seen++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic enter_sleep();
        sleep_enter = 1'b1; sleep_active = 1'b1;
        tick(1);
        sleep_enter = 1'b0;
    endtask

    task automatic try_wake(input string tag, input logic [2:0] sel, input logic pol,
                            input logic dly, input logic an,
                            input logic [7:0] ai, input logic [7:0] aa,
                            input logic [3:0] bi, input logic [3:0] ba,
                            input int hold, input int exp);
        cur_req = tag;
        sleep_active = 1'b0;
        analog_en = an;
        wr({3'b000, dly, pol, sel});
        pa_pad = ai; pb_pad = bi;
        tick(4);
        enter_sleep();
        wake_seen = 0;
        pa_pad = aa; pb_pad = ba;
        tick(hold);
        pa_pad = ai; pb_pad = bi;
        tick(6);
        cmp("wake count", 8'(wake_seen), 8'(exp));
        sleep_active = 1'b0;
        tick(2);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        cur_req = "R1";
        cmp("reset rdata", cfg_rdata, 8'h10);
        cmp("reset outputs", {5'b0, wake_pulse, long_delay_req, fast_restart_req}, 8'h00);

        // R2: readback, bit 7 write ignored
        cur_req = "R2";
        wr(8'hFF);
        cmp("rdata after FF", cfg_rdata, 8'h1F);
        wr(8'h00);
        cmp("rdata after 00", cfg_rdata, 8'h00);

        // R3: single pins
        try_wake("R3", 3'd1, 1, 1, 0, 8'h00, 8'h00, 4'h0, 4'h1, 3, 1);
        try_wake("R3", 3'd2, 1, 1, 0, 8'h00, 8'h00, 4'h0, 4'h2, 3, 1);
        try_wake("R3", 3'd3, 1, 1, 0, 8'h00, 8'h00, 4'h0, 4'h4, 3, 1);
        try_wake("R3", 3'd4, 1, 1, 0, 8'h00, 8'h00, 4'h0, 4'h8, 3, 1);
        try_wake("R3", 3'd5, 1, 1, 0, 8'h00, 8'h80, 4'h0, 4'h0, 3, 1);
        try_wake("R3", 3'd1, 1, 1, 0, 8'h00, 8'h00, 4'h0, 4'hE, 3, 0);
        // R4: NOR groups
        try_wake("R4", 3'd6, 1, 1, 0, 8'h01, 8'hF0, 4'h0, 4'h0, 3, 1);
        try_wake("R4", 3'd7, 1, 1, 0, 8'h10, 8'h00, 4'h0, 4'h0, 3, 1);
        try_wake("R4", 3'd7, 1, 1, 0, 8'h10, 8'h80, 4'h0, 4'h0, 3, 0);
        // R5: code 0
        try_wake("R5", 3'd0, 1, 1, 0, 8'h00, 8'hFF, 4'h0, 4'hF, 3, 0);
        try_wake("R5", 3'd0, 0, 0, 0, 8'hFF, 8'h00, 4'hF, 4'h0, 9, 0);
        // R6: analog gating
        try_wake("R6", 3'd2, 1, 1, 1, 8'h00, 8'h00, 4'h0, 4'hF, 3, 0);
        try_wake("R6", 3'd3, 1, 1, 1, 8'h00, 8'h00, 4'h0, 4'hF, 3, 0);
        try_wake("R6", 3'd4, 1, 1, 1, 8'h00, 8'h00, 4'h0, 4'hF, 3, 0);
        try_wake("R6", 3'd1, 1, 1, 1, 8'h00, 8'h00, 4'h0, 4'h1, 3, 1);
        // R7: low-level polarity
        try_wake("R7", 3'd1, 0, 1, 0, 8'h00, 8'h00, 4'hF, 4'hE, 3, 1);
        try_wake("R7", 3'd6, 0, 1, 0, 8'h00, 8'h0F, 4'h0, 4'h0, 3, 1);
        // R9: fast restart qualification
        try_wake("R9", 3'd1, 1, 0, 0, 8'h00, 8'h00, 4'h0, 4'h1, 4, 0);
        try_wake("R9", 3'd1, 1, 0, 0, 8'h00, 8'h00, 4'h0, 4'h1, 9, 1);

        // R8: exact latency
        cur_req = "R8";
        analog_en = 0;
        wr(8'h19);
        pb_pad = 4'h0;
        tick(4);
        enter_sleep();
        tick(4);
        pb_pad = 4'h1;
        tick(2);
        cmp("wake before third edge", {7'b0, wake_pulse}, 8'h00);
        tick(1);
        cmp("wake at third edge", {7'b0, wake_pulse}, 8'h01);
        cmp("long delay with wake", {7'b0, long_delay_req}, 8'h01);
        // R10: held source gives one wake only
        cur_req = "R10";
        wake_seen = 0;
        tick(10);
        cmp("no repeat wake", 8'(wake_seen), 8'h00);
        pb_pad = 4'h0;
        sleep_active = 1'b0;
        tick(3);
        pb_pad = 4'h1;
        tick(10);
        cmp("no wake while awake", 8'(wake_seen), 8'h00);
        pb_pad = 4'h0;
        tick(3);

        // R11: warm status
        cur_req = "R11";
        cmp("warm after sleep", {7'b0, warm_start}, 8'h01);
        wr(8'h00);
        cmp("warm write ignored", cfg_rdata, 8'h80);

        // R12: output-enabled bit
        pa_oe = 8'h80; pa_dout = 8'h80;
        try_wake("R12", 3'd5, 1, 1, 0, 8'h00, 8'h00, 4'h0, 4'h0, 3, 1);
        pa_dout = 8'h00;
        try_wake("R12", 3'd5, 1, 1, 0, 8'h00, 8'h80, 4'h0, 4'h0, 3, 0);
        pa_oe = 8'h00;

        // R13: gap restarts qualification
        cur_req = "R13";
        wr(8'h01);
        pb_pad = 4'h0;
        tick(4);
        enter_sleep();
        wake_seen = 0;
        pb_pad = 4'h1; tick(4);
        pb_pad = 4'h0; tick(1);
        pb_pad = 4'h1; tick(4);
        pb_pad = 4'h0; tick(6);
        cmp("gap blocks wake", 8'(wake_seen), 8'h00);
        sleep_active = 1'b0;
        tick(2);

        // R11: reset clears warm status
        cur_req = "R11";
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        cmp("warm cleared by reset", cfg_rdata, 8'h10);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule